// File: doc/BRIEF.md
# I2C Register-Write Frame Master

This block is a transmit-only bus master for a two-wire open-drain serial bus. Every transaction writes one byte into one register of one target. Each frame has a fixed layout: a start condition, the 7-bit target address, a write bit, an acknowledge slot, an 8-bit register index, an acknowledge slot, one data byte, and a final acknowledge slot. The host loads up to `DEPTH` frames into an internal queue. It then raises `go`. The `chain` input picks how the frames are linked on the wire. With `chain` low, each frame is closed by its own stop, and the next frame opens with a fresh start. With `chain` high, each frame after the first opens with a repeated start, and one stop closes the whole sequence.

The serial clock is the system clock divided by `CLK_DIV`, which defaults to 15. A counter splits each serial-clock period into four quarters. The boundaries fall at `floor(k*CLK_DIV/4)` system clocks, for k = 0 to 3. Both lines are only pulled low or released, and the block never drives a line high. If the target answers any acknowledge slot with a high level, the sequence is cut short: a stop is sent, the remaining frames are dropped, and a sticky error flag is set.

Top module: `i2cw_master`

## Requirements
- R1: After synchronous reset, `scl_oe`, `sda_oe`, `busy`, `done` and `nack_error` are all 0. While `busy` is 0, both `scl_oe` and `sda_oe` are 0. An output enable of 1 pulls its line low, and 0 releases it.
- R2: Each frame sends its bits most significant bit first: the 7 address bits, then a 0 write bit, then a released acknowledge slot, then 8 register bits, a slot, 8 data bits and a slot. A data bit is applied one system clock after the first quarter boundary of its period, while SCL is held low. SCL and SDA never change in the same system clock.
- R3: A start condition pulls SDA low while SCL is released, one system clock after the third quarter boundary. A start that follows idle does not pull SCL low first.
- R4: In each acknowledge slot the master releases SDA. It samples SDA at the third quarter boundary, and a low level there lets the frame continue.
- R5: With `chain` low, every frame ends with a stop, and the following frame begins from idle with a new start, with `busy` held high throughout.
- R6: With `chain` high, each later frame begins with a repeated start: SCL low, SDA released, SCL released, then SDA pulled low. Only the last frame ends with a stop.
- R7: A stop pulls SDA low while SCL is low, releases SCL, and then releases SDA while SCL is high.
- R8: A high level sampled in any acknowledge slot sets `nack_error` in the next cycle. The next slot becomes a stop, and all queued frames are discarded. `nack_error` stays set until a later accepted `go`.
- R9: `busy` rises in the cycle after an accepted `go`. It falls in the same cycle in which the final stop releases SDA, and `done` is high for exactly that one cycle.
- R10: One serial-clock period is `CLK_DIV` system clocks. The first period begins in the cycle after `go` is accepted, and later periods follow back to back.
- R11: `push` stores one frame while fewer than `DEPTH` frames are queued. A push made when the queue already holds `DEPTH` frames is dropped and is never sent.
- R12: `go` is accepted only when `busy` is 0 and the queue is non-empty. A `go` with an empty queue has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Append one frame to the queue |
| push_dev | input | 7 | Target address of the pushed frame |
| push_reg | input | 8 | Register index of the pushed frame |
| push_val | input | 8 | Data byte of the pushed frame |
| go | input | 1 | Start sending the queued frames |
| chain | input | 1 | 1: link frames by repeated start; 0: stop after every frame |
| sda_in | input | 1 | Level seen on the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the final stop completes |
| nack_error | output | 1 | Sticky flag for a missing acknowledge |

## Verification
The hardest case to reach is a missing acknowledge in the middle of a chained sequence while more frames are still queued. Here the abort, the flush and the sticky flag all have to take effect together. The bench models a target that pulls SDA low in each acknowledge slot. It can be told to withhold the acknowledge at a chosen slot index across the whole sequence, which lands the NACK on an address, register or data slot of any frame. After the abort, the bench raises `go` against what should be an empty queue. This shows at the ports that the flush happened and that the flag survives the ignored request.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int FRAME_SLOTS = 27;

    typedef struct packed {
        logic [6:0] dev;
        logic [7:0] reg_addr;
        logic [7:0] value;
    } wr_frame_t;

    typedef enum logic [1:0] {
        SL_IDLE,
        SL_START,
        SL_BIT,
        SL_STOP
    } slot_e;

    // Serial image of one frame; a 1 in an acknowledge position means "release".
    function automatic logic [FRAME_SLOTS-1:0] frame_bits(wr_frame_t f);
        return {f.dev, 1'b0, 1'b1, f.reg_addr, 1'b1, f.value, 1'b1};
    endfunction

    function automatic logic is_ack_slot(logic [4:0] idx);
        return (idx == 5'd8) || (idx == 5'd17) || (idx == 5'd26);
    endfunction

endpackage

// File: rtl/i2cw_fifo.sv
module i2cw_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 23
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/i2cw_phase_gen.sv
module i2cw_phase_gen #(
    parameter int CLK_DIV = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    output logic       tick,
    output logic [1:0] phase
);
    localparam int CW = $clog2(CLK_DIV);
    localparam int B1 = CLK_DIV / 4;
    localparam int B2 = CLK_DIV / 2;
    localparam int B3 = (3 * CLK_DIV) / 4;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)               cnt <= '0;
        else if (cnt == CW'(CLK_DIV-1)) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    always_comb begin
        tick  = run && ((cnt == '0) || (cnt == CW'(B1)) ||
                        (cnt == CW'(B2)) || (cnt == CW'(B3)));
        if (cnt == '0)          phase = 2'd0;
        else if (cnt == CW'(B1)) phase = 2'd1;
        else if (cnt == CW'(B2)) phase = 2'd2;
        else                    phase = 2'd3;
    end
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
    import i2cw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] phase,
    input  logic       start_req,
    input  logic       chain,
    input  logic       q_empty,
    input  wr_frame_t  q_head,
    input  logic       sda_in,
    output logic       q_pop,
    output logic       q_flush,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output logic       nack_error
);
    slot_e                  slot;
    logic [4:0]             idx;
    logic [FRAME_SLOTS-1:0] bits;
    logic                   from_idle, chain_r;
    logic                   advance, nack_hit, chain_next, reload_idle;

    always_comb begin
        advance     = tick && (phase == 2'd3);
        nack_hit    = advance && (slot == SL_BIT) && is_ack_slot(idx) && sda_in;
        chain_next  = advance && (slot == SL_BIT) && (idx == 5'd26) &&
                      chain_r && !q_empty && !nack_hit;
        reload_idle = advance && (slot == SL_STOP) && !q_empty;
        q_pop       = start_req || chain_next || reload_idle;
        q_flush     = nack_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot       <= SL_IDLE;
            idx        <= '0;
            bits       <= '0;
            from_idle  <= 1'b0;
            chain_r    <= 1'b0;
            scl_oe     <= 1'b0;
            sda_oe     <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
            nack_error <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start_req) begin
                slot       <= SL_START;
                from_idle  <= 1'b1;
                bits       <= frame_bits(q_head);
                chain_r    <= chain;
                busy       <= 1'b1;
                nack_error <= 1'b0;
            end else if (tick) begin
                case (phase)
                    2'd0: scl_oe <= !((slot == SL_START) && from_idle);
                    2'd1: begin
                        if (slot == SL_STOP)       sda_oe <= 1'b1;
                        else if (slot == SL_START) sda_oe <= 1'b0;
                        else                       sda_oe <= !bits[FRAME_SLOTS-1];
                    end
                    2'd2: scl_oe <= 1'b0;
                    default: begin
                        case (slot)
                            SL_START: begin
                                sda_oe <= 1'b1;
                                slot   <= SL_BIT;
                                idx    <= '0;
                            end
                            SL_BIT: begin
                                if (nack_hit) begin
                                    nack_error <= 1'b1;
                                    slot       <= SL_STOP;
                                end else if (idx == 5'd26) begin
                                    if (chain_next) begin
                                        slot      <= SL_START;
                                        from_idle <= 1'b0;
                                        bits      <= frame_bits(q_head);
                                    end else begin
                                        slot <= SL_STOP;
                                    end
                                end else begin
                                    idx  <= idx + 1'b1;
                                    bits <= bits << 1;
                                end
                            end
                            SL_STOP: begin
                                sda_oe <= 1'b0;
                                if (reload_idle) begin
                                    slot      <= SL_START;
                                    from_idle <= 1'b1;
                                    bits      <= frame_bits(q_head);
                                end else begin
                                    slot <= SL_IDLE;
                                    busy <= 1'b0;
                                    done <= 1'b1;
                                end
                            end
                            default: slot <= SL_IDLE;
                        endcase
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
    import i2cw_pkg::*;
#(
    parameter int CLK_DIV = 15,
    parameter int DEPTH   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [6:0] push_dev,
    input  logic [7:0] push_reg,
    input  logic [7:0] push_val,
    input  logic       go,
    input  logic       chain,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output logic       nack_error
);
    localparam int FW = $bits(wr_frame_t);

    wr_frame_t  in_fr, head;
    logic       q_empty, q_full, q_pop, q_flush;
    logic       tick, start_req;
    logic [1:0] phase;

    assign in_fr     = '{dev: push_dev, reg_addr: push_reg, value: push_val};
    assign start_req = go && !busy && !q_empty;

    i2cw_fifo #(.DEPTH(DEPTH), .W(FW)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (in_fr),
        .pop   (q_pop),
        .flush (q_flush),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    i2cw_phase_gen #(.CLK_DIV(CLK_DIV)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .run   (busy),
        .tick  (tick),
        .phase (phase)
    );

    i2cw_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .phase      (phase),
        .start_req  (start_req),
        .chain      (chain),
        .q_empty    (q_empty),
        .q_head     (head),
        .sda_in     (sda_in),
        .q_pop      (q_pop),
        .q_flush    (q_flush),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .busy       (busy),
        .done       (done),
        .nack_error (nack_error)
    );

    logic unused_full;
    assign unused_full = q_full;
endmodule

// File: rtl/i2cw_master_chk.sv
module i2cw_master_chk (
    input logic clk,
    input logic rst,
    input logic go,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic done,
    input logic nack_error
);
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe));

    p_one_line_moves_r2: assert property (@(posedge clk) disable iff (rst)
        (scl_oe != $past(scl_oe)) |-> (sda_oe == $past(sda_oe)));

    p_nack_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (nack_error && !go) |=> nack_error);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_busy_needs_go_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go));
endmodule

bind i2cw_master i2cw_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .busy       (busy),
    .done       (done),
    .nack_error (nack_error)
);

// File: tb/tb_i2cw_master.sv
module tb_i2cw_master;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 15;
    localparam int DEPTH = 4;
    localparam int B1 = DIV / 4;
    localparam int B2 = DIV / 2;
    localparam int B3 = (3 * DIV) / 4;
    localparam int K_START = 0, K_BIT = 1, K_STOP = 2;

    logic clk = 0, rst = 1;
    logic push = 0, go = 0, chain = 0, slave_pull = 0;
    logic [6:0] push_dev = 0;
    logic [7:0] push_reg = 0, push_val = 0;
    logic scl_oe, sda_oe, busy, done, nack_error, sda_in;

    logic exp_scl = 0, exp_sda = 0, exp_busy = 0, exp_done = 0, exp_nack = 0;
    int checks = 0, errors = 0;
    string cur = "R1";
    logic [22:0] mq[$];

    assign sda_in = !(sda_oe || slave_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cw_master #(.CLK_DIV(DIV), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .push(push), .push_dev(push_dev), .push_reg(push_reg),
        .push_val(push_val), .go(go), .chain(chain), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .nack_error(nack_error)
    );

    task automatic tick_check();
        @(negedge clk);
        checks++;
        if (scl_oe !== exp_scl || sda_oe !== exp_sda || busy !== exp_busy ||
            done !== exp_done || nack_error !== exp_nack) begin
            errors++;
            $display("FAIL %s t=%0t act scl=%b sda=%b busy=%b done=%b nack=%b exp %b %b %b %b %b",
                     cur, $time, scl_oe, sda_oe, busy, done, nack_error,
                     exp_scl, exp_sda, exp_busy, exp_done, exp_nack);
        end
    endtask

    task automatic push_frame(input logic [6:0] d, input logic [7:0] r, input logic [7:0] v);
        push = 1; push_dev = d; push_reg = r; push_val = v;
        if (mq.size() < DEPTH) mq.push_back({d, r, v});
        tick_check();
        push = 0;
    endtask

    task automatic do_slot(input int kind, input logic b, input logic idle_start,
                           input logic ack, input logic nack, input logic last);
        for (int c = 0; c < DIV; c++) begin
            if (c == 1) begin
                slave_pull = ack && !nack;
                if (!(kind == K_START && idle_start)) exp_scl = 1;
            end
            if (c == B1 + 1)
                exp_sda = (kind == K_STOP) ? 1'b1 : (kind == K_START) ? 1'b0 : (ack ? 1'b0 : !b);
            if (c == B2 + 1) exp_scl = 0;
            if (c == B3 + 1) begin
                if (kind == K_START) exp_sda = 1;
                if (ack && nack) exp_nack = 1;
                if (kind == K_STOP) begin
                    exp_sda = 0;
                    if (last) begin exp_busy = 0; exp_done = 1; end
                end
            end
            if (c == B3 + 2 && kind == K_STOP && last) exp_done = 0;
            tick_check();
            go = 0;
            if (kind == K_STOP && last && c == B3 + 2) break;
        end
    endtask

    function automatic logic fbit(input logic [22:0] f, input int i);
        if (i < 7)  return f[22 - i];
        if (i < 9)  return 1'b0;
        if (i < 18) return f[15 - (i - 9)];
        return f[7 - (i - 18)];
    endfunction

    task automatic run_seq(input logic ch, input int nack_at, input string tag);
        int ackn = 0;
        logic first = 1;
        logic [22:0] f;
        logic lastf;
        cur = tag; chain = ch;
        if (mq.size() == 0) begin
            go = 1; tick_check(); go = 0;
            repeat (4) tick_check();
            return;
        end
        go = 1; exp_busy = 1; exp_nack = 0;
        forever begin
            f = mq.pop_front();
            do_slot(K_START, 1'b0, first || !ch, 1'b0, 1'b0, 1'b0);
            first = 0;
            for (int i = 0; i < 27; i++) begin
                logic isack, nk;
                isack = (i == 8) || (i == 17) || (i == 26);
                nk = isack && (ackn == nack_at);
                do_slot(K_BIT, fbit(f, i), 1'b0, isack, nk, 1'b0);
                if (isack) ackn++;
                if (nk) begin
                    mq.delete();
                    do_slot(K_STOP, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
                    repeat (3) tick_check();
                    return;
                end
            end
            if (ch && mq.size() > 0) continue;
            lastf = (mq.size() == 0);
            do_slot(K_STOP, 1'b0, 1'b0, 1'b0, 1'b0, lastf);
            if (lastf) begin
                repeat (3) tick_check();
                return;
            end
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired in %s", cur);
        finish_run();
    end

    initial begin
        // R1: reset values and quiet lines
        cur = "R1";
        repeat (4) tick_check();
        rst = 0;
        repeat (3) tick_check();

        // R2 R3 R4 R5 R7 R9 R10: two separate frames, each with its own start/stop
        push_frame(7'h5A, 8'h3C, 8'hA5);
        push_frame(7'h21, 8'h80, 8'h01);
        run_seq(1'b0, -1, "R5");

        // R6: three frames joined by repeated starts
        push_frame(7'h7F, 8'h00, 8'hFF);
        push_frame(7'h00, 8'hFF, 8'h00);
        push_frame(7'h33, 8'hC3, 8'h5E);
        run_seq(1'b1, -1, "R6");

        // R11: fifth push into a full queue is dropped
        push_frame(7'h11, 8'h22, 8'h33);
        push_frame(7'h44, 8'h55, 8'h66);
        push_frame(7'h0F, 8'hF0, 8'h99);
        push_frame(7'h70, 8'h0E, 8'h18);
        push_frame(7'h6B, 8'hB6, 8'h7C);
        run_seq(1'b1, -1, "R11");

        // R12: go with an empty queue does nothing
        run_seq(1'b0, -1, "R12");

        // R8: NACK on register slot of first chained frame; second frame flushed
        push_frame(7'h2A, 8'h10, 8'h20);
        push_frame(7'h15, 8'h30, 8'h40);
        run_seq(1'b1, 1, "R8");
        // R8: flag survives an ignored go on the flushed queue
        run_seq(1'b1, -1, "R8");

        // R8: flag cleared by next accepted go; NACK on address slot in separate mode
        push_frame(7'h3E, 8'h01, 8'h02);
        push_frame(7'h41, 8'h03, 8'h04);
        run_seq(1'b0, 0, "R8");

        // R4 R9: NACK on the final data slot still ends with a single stop
        push_frame(7'h09, 8'h90, 8'hE7);
        run_seq(1'b0, 2, "R9");

        // R4: clean run after errors clears the flag
        push_frame(7'h55, 8'hAA, 8'h55);
        run_seq(1'b0, -1, "R4");

        finish_run();
    end
endmodule